// File: doc/BRIEF.md
# Multicycle 16-bit Shared-Bus Processor

This block is a small multicycle processor with a 16-bit datapath. It has eight general registers, an operand latch `A` that feeds the adder, and a result latch `G` that holds its output. All of them sit on one internal 16-bit bus. Each cycle a one-hot select picks exactly one bus driver: a register, `G`, or the `din` input. The bus value is brought out on `bus_out` so that software-free tests can watch every transfer.

A two-bit step counter runs each instruction. In step T0 the block waits for `run`. When `run` is seen, it latches the 9-bit instruction word from the low bits of `din` and moves to T1. Each opcode then takes its own number of steps. `done` is high in the final step, and the counter then goes back to T0.

Memory is reached through a registered address port, a registered write-data port and a one-cycle write strobe. Load data comes back on `din`.

Top module: `bus_cpu16`

## Requirements
- R1: After reset is released, `done` and `wr` are low. All eight registers, `A` and `G` read as zero. The step counter is in T0.
- R2: In T0 with no `run`, the block stays in T0, `done` stays low and `bus_out` shows `din`. With `run` high, `din[8:6]` is latched as the opcode, `din[5:3]` as the destination field Rx and `din[2:0]` as the source field Ry. `din[15:9]` is ignored.
- R3: Opcode 000 (copy) drives Ry onto the bus in T1 and writes it into Rx. `done` is high in that cycle, one cycle after the instruction was accepted.
- R4: Opcode 001 (immediate) writes the `din` value present in T1 into Rx. `done` is high in T1.
- R5: Opcode 010 runs three steps: T1 loads `A` from Rx, T2 loads `G` with `A` + Ry, and T3 drives `G` onto the bus and writes Rx. `done` is high in T3. The sum wraps modulo 2^16.
- R6: Opcode 011 uses the same three steps as R5, but `G` is loaded with `A` − Ry, wrapping modulo 2^16.
- R7: Opcode 100 (load) places Ry on `addr` from T2. In T2 it writes the `din` value into Rx, with `done` high.
- R8: Opcode 101 (store) sets `addr` to Ry and `dout` to Rx, with `done` in T2. `wr` is high for exactly the one cycle after T2.
- R9: Opcode 110 writes Ry into Rx in T1 only if `G` is nonzero. If `G` is zero, Rx is unchanged. `done` is high in T1 either way, and the bus shows Ry.
- R10: Opcode 111 finishes in T1 with `done` high and changes no register. The bus shows `din`.
- R11: Exactly one bus source is selected in every cycle. `done` never stays high for two cycles in a row, and the step after `done` is T0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start request sampled in T0 |
| din | input | 16 | Instruction word, immediate value, or load data |
| done | output | 1 | High in the final step of an instruction |
| bus_out | output | 16 | Current internal bus value |
| addr | output | 16 | Memory address register |
| dout | output | 16 | Memory write data register |
| wr | output | 1 | Memory write strobe, one cycle |

## Verification
Counted from the T0 cycle in which `run` is accepted, `done` is due 1 cycle later for copy, immediate, conditional copy and no-op, 2 cycles later for load and store, and 3 cycles later for add and subtract. The `wr` pulse comes one further cycle after a store's `done`. The driver records the cycle in which it issued the instruction and queues the expected bus value together with the cycle in which it is due. The monitor checks both the value and the arrival cycle on every `done`. Inputs change 2 ns after a rising edge and outputs are sampled on the falling edge, so every sample falls in a settled cycle. Register contents that a conditional copy or a no-op must not alter are read back afterwards with a self-copy.

// File: rtl/bus_cpu16.sv
`timescale 1ns/1ps
module bus_cpu16 #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int IW   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] din,
  output logic         done,
  output logic [W-1:0] bus_out,
  output logic [W-1:0] addr,
  output logic [W-1:0] dout,
  output logic         wr
);
  localparam int RW      = $clog2(NREG);
  localparam int OPW     = IW - 2*RW;
  localparam int NSRC    = NREG + 2;
  localparam int SRC_G   = NREG;
  localparam int SRC_DIN = NREG + 1;

  localparam logic [OPW-1:0] OP_MV   = 3'd0;
  localparam logic [OPW-1:0] OP_MVI  = 3'd1;
  localparam logic [OPW-1:0] OP_ADD  = 3'd2;
  localparam logic [OPW-1:0] OP_SUB  = 3'd3;
  localparam logic [OPW-1:0] OP_LD   = 3'd4;
  localparam logic [OPW-1:0] OP_ST   = 3'd5;
  localparam logic [OPW-1:0] OP_MVNZ = 3'd6;

  logic [1:0]          step;
  logic [IW-1:0]       ir;
  logic [W-1:0]        regs [NREG];
  logic [W-1:0]        a_q, g_q;
  logic [W-1:0]        bus;
  logic [W-1:0]        alu;
  logic [NSRC-1:0]     sel;
  logic [NREG-1:0]     rin;
  logic                ain, gin, addr_in, dout_in, last;

  wire [OPW-1:0] op = ir[IW-1 -: OPW];
  wire [RW-1:0]  rx = ir[2*RW-1 -: RW];
  wire [RW-1:0]  ry = ir[RW-1:0];

  wire [NREG-1:0] xdec = NREG'(1) << rx;
  wire [NREG-1:0] ydec = NREG'(1) << ry;
  wire [NSRC-1:0] sel_x   = {2'b00, xdec};
  wire [NSRC-1:0] sel_y   = {2'b00, ydec};
  wire [NSRC-1:0] sel_g   = NSRC'(1) << SRC_G;
  wire [NSRC-1:0] sel_din = NSRC'(1) << SRC_DIN;

  always_comb begin
    sel     = sel_din;
    rin     = '0;
    ain     = 1'b0;
    gin     = 1'b0;
    addr_in = 1'b0;
    dout_in = 1'b0;
    last    = 1'b0;
    case (step)
      2'd1: begin
        case (op)
          OP_MV:   begin sel = sel_y; rin = xdec; last = 1'b1; end
          OP_MVI:  begin sel = sel_din; rin = xdec; last = 1'b1; end
          OP_ADD,
          OP_SUB:  begin sel = sel_x; ain = 1'b1; end
          OP_LD,
          OP_ST:   begin sel = sel_y; addr_in = 1'b1; end
          OP_MVNZ: begin
            sel  = sel_y;
            rin  = (g_q != '0) ? xdec : '0;
            last = 1'b1;
          end
          default: last = 1'b1;
        endcase
      end
      2'd2: begin
        case (op)
          OP_ADD,
          OP_SUB:  begin sel = sel_y; gin = 1'b1; end
          OP_LD:   begin sel = sel_din; rin = xdec; last = 1'b1; end
          OP_ST:   begin sel = sel_x; dout_in = 1'b1; last = 1'b1; end
          default: last = 1'b1;
        endcase
      end
      2'd3: begin
        sel  = sel_g;
        rin  = xdec;
        last = 1'b1;
      end
      default: ;
    endcase
  end

  logic [W-1:0] src [NSRC];
  logic [W-1:0] gated [NSRC];
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_src_reg
      assign src[gi] = regs[gi];
    end
  endgenerate
  assign src[SRC_G]   = g_q;
  assign src[SRC_DIN] = din;

  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_gate
      assign gated[gi] = sel[gi] ? src[gi] : '0;
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | gated[i];
  end

  assign alu = (op == OP_SUB) ? (a_q - bus) : (a_q + bus);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= 2'd0;
      ir   <= '0;
    end else if (step == 2'd0) begin
      if (run) begin
        ir   <= din[IW-1:0];
        step <= 2'd1;
      end
    end else if (last) begin
      step <= 2'd0;
    end else begin
      step <= step + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (rin[i]) regs[i] <= bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      g_q  <= '0;
      addr <= '0;
      dout <= '0;
      wr   <= 1'b0;
    end else begin
      if (ain)     a_q  <= bus;
      if (gin)     g_q  <= alu;
      if (addr_in) addr <= bus;
      if (dout_in) dout <= bus;
      wr <= dout_in;
    end
  end

  assign done    = last;
  assign bus_out = bus;
endmodule

// File: rtl/bus_cpu16_chk.sv
`timescale 1ns/1ps
module bus_cpu16_chk #(
  parameter int NSRC = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [1:0]      step,
  input logic [NSRC-1:0] sel,
  input logic            done,
  input logic            wr
);
  assert_one_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_back_to_t0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> step == 2'd0);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd0 && !run) |=> step == 2'd0);

  assert_idle_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd0) |-> !done);

  assert_t3_finishes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'd3) |-> done);

  assert_wr_follows_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $past(done));

  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !wr);
endmodule

bind bus_cpu16 bus_cpu16_chk #(.NSRC(NREG + 2)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .run  (run),
  .step (step),
  .sel  (sel),
  .done (done),
  .wr   (wr)
);

// File: tb/bus_cpu16_test.sv
`timescale 1ns/1ps
module bus_cpu16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] din = 16'h0000;
  logic        done, wr;
  logic [15:0] bus_out, addr, dout;

  bus_cpu16 uut (
    .clk(clk), .rst_n(rst_n), .run(run), .din(din), .done(done),
    .bus_out(bus_out), .addr(addr), .dout(dout), .wr(wr)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [15:0] val;
    int          due;
    bit          chk_addr;
    logic [15:0] exp_addr;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          live = 1'b0;
  logic [15:0] m [8];
  logic [15:0] mg = 16'h0000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected done", 32'(bus_out), 32'hFFFFFFFF);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc == it.due, {it.tag, " done cycle"}, 32'(cyc), 32'(it.due));
          check(bus_out == it.val, {it.tag, " bus value"}, 32'(bus_out), 32'(it.val));
          if (it.chk_addr)
            check(addr == it.exp_addr, {it.tag, " address"}, 32'(addr), 32'(it.exp_addr));
        end
      end
    end
  end

  task automatic exec(input logic [2:0] op, input logic [2:0] x, input logic [2:0] y,
                      input logic [15:0] imm, input string tag);
    item_t it;
    int lat;
    @(posedge clk); #2;
    din = {7'h5A, op, x, y};
    run = 1'b1;
    it.due = cyc;
    it.chk_addr = 1'b0;
    it.exp_addr = 16'h0;
    it.tag = tag;
    case (op)
      3'd0: begin lat = 1; it.val = m[y]; m[x] = m[y]; end
      3'd1: begin lat = 1; it.val = imm; m[x] = imm; end
      3'd2: begin lat = 3; mg = m[x] + m[y]; it.val = mg; m[x] = mg; end
      3'd3: begin lat = 3; mg = m[x] - m[y]; it.val = mg; m[x] = mg; end
      3'd4: begin lat = 2; it.val = imm; it.chk_addr = 1'b1; it.exp_addr = m[y]; m[x] = imm; end
      3'd5: begin lat = 2; it.val = m[x]; it.chk_addr = 1'b1; it.exp_addr = m[y]; end
      3'd6: begin lat = 1; it.val = m[y]; if (mg != 16'h0) m[x] = m[y]; end
      default: begin lat = 1; it.val = imm; end
    endcase
    it.due = it.due + lat;
    sb.push_back(it);
    @(posedge clk); #2;
    run = 1'b0;
    din = imm;
    for (int k = 1; k < lat; k++) begin
      @(posedge clk); #2;
    end
    if (op == 3'd5) begin
      logic [15:0] ea, ed;
      ea = it.exp_addr;
      ed = it.val;
      @(posedge clk); #2;
      @(negedge clk);
      check(wr == 1'b1, "R8 wr pulse", 32'(wr), 32'h1);
      check(dout == ed, "R8 dout", 32'(dout), 32'(ed));
      check(addr == ea, "R8 addr", 32'(addr), 32'(ea));
      @(posedge clk); #2;
      @(negedge clk);
      check(wr == 1'b0, "R8 wr single", 32'(wr), 32'h0);
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 16'h0000;
    din = 16'h3C3C;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done low", 32'(done), 32'h0);
    check(wr == 1'b0, "R1 wr low", 32'(wr), 32'h0);
    check(bus_out == 16'h3C3C, "R2 idle bus shows din", 32'(bus_out), 32'h3C3C);
    live = 1'b1;

    exec(3'd0, 3'd7, 3'd5, 16'h0000, "R1 reset register");
    exec(3'd1, 3'd1, 3'd0, 16'h0005, "R4 immediate");
    exec(3'd1, 3'd2, 3'd0, 16'hFFFE, "R4 immediate");
    exec(3'd0, 3'd3, 3'd1, 16'h0000, "R3 copy");
    exec(3'd2, 3'd1, 3'd2, 16'h0000, "R5 add wrap");
    exec(3'd3, 3'd3, 3'd2, 16'h0000, "R6 subtract wrap");
    exec(3'd6, 3'd4, 3'd1, 16'h0000, "R9 G nonzero");
    exec(3'd0, 3'd4, 3'd4, 16'h0000, "R9 written readback");
    exec(3'd3, 3'd5, 3'd5, 16'h0000, "R6 subtract to zero");
    exec(3'd6, 3'd6, 3'd2, 16'h0000, "R9 G zero");
    exec(3'd0, 3'd6, 3'd6, 16'h0000, "R9 unchanged readback");
    exec(3'd7, 3'd1, 3'd2, 16'h1234, "R10 no-op");
    exec(3'd0, 3'd1, 3'd1, 16'h0000, "R10 unchanged readback");
    exec(3'd4, 3'd7, 3'd1, 16'hBEEF, "R7 load");
    exec(3'd5, 3'd7, 3'd4, 16'h0000, "R8 store");
    din = 16'h0A0A;
    repeat (6) begin
      @(negedge clk);
      check(done == 1'b0, "R2 idle no done", 32'(done), 32'h0);
    end
    exec(3'd2, 3'd0, 3'd7, 16'h0000, "R5 add");
    exec(3'd0, 3'd2, 3'd0, 16'h0000, "R3 copy");
    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R11 all done seen", 32'(sb.size()), 32'h0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule